// File: doc/BRIEF.md
# Coprocessor Bus Address Decoder

This block sits between a graphics coprocessor and its two local memories, a program ROM and a work RAM. The coprocessor presents one 24-bit byte address at a time with a request/ready handshake. The block decides which memory the address belongs to and forms the physical offset for that memory. It then issues a single read or write strobe and returns the read byte to the coprocessor.

Both memories are shared with a host processor. A per-memory ownership input tells the block whether the coprocessor currently holds that memory. While it does not, the access waits. Ownership is sampled once per polling interval of a fixed number of cycles, so a grant that arrives between two samples takes effect only at the next sample.

The ROM is reached through two windows. In the lower window each 64 KB bank contributes only its upper 32 KB half, and these halves are packed one after another. In the upper window the address is used flat. The RAM has one window. Only the RAM window accepts writes. Reads outside every window complete at once with a zero byte. The memory sizes are given as masks, each equal to the size minus one.

Top module: `cpbus_decoder`

## Requirements
- R1: When address bits 23:22 are 00, a read goes to the ROM at offset {addr[21:16], addr[14:0]}. Address bit 15 does not affect the offset.
- R2: When address bits 23:21 are 010, a read goes to the ROM at offset addr[ROM_AW-1:0] AND the ROM size mask.
- R3: When address bits 23:21 are 011, an access goes to the RAM at offset addr[RAM_AW-1:0] AND the RAM size mask. Both reads and writes are allowed there, and a write drives its data byte on the RAM write port.
- R4: A read whose address is in none of the three windows (bits 23 set, or 23:21 equal to 001 is not such a case since that is ROM; i.e. bit 23 = 1) raises no memory strobe. It completes with req_ready on the first cycle after acceptance, with rsp_rdata = 0x00.
- R5: A write outside the RAM window raises no memory strobe and completes with req_ready on the first cycle after acceptance.
- R6: No ROM strobe is issued unless rom_owned was high in the previous cycle. No RAM strobe is issued unless ram_owned was high in the previous cycle. While ownership is low, the access stays pending.
- R7: Ownership is first sampled in the cycle after acceptance and then once every POLL_CYCLES (6) cycles. The strobe follows the first high sample by one cycle, so it appears 2 + 6k cycles after the request is driven, where k is the number of low samples.
- R8: req_ready is a one-cycle pulse. It rises in the cycle after the selected memory asserts its read-valid, or in the cycle after a RAM write strobe.
- R9: At most one access is outstanding. Each accepted mapped request produces exactly one single-cycle strobe, and no two strobes are ever active together.
- R10: In the lower ROM window, the folded offset is ANDed with the ROM size mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address from the coprocessor |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read byte, valid with req_ready |
| rom_owned | input | 1 | Coprocessor holds the ROM |
| ram_owned | input | 1 | Coprocessor holds the RAM |
| rom_size_mask | input | ROM_AW | ROM size minus one |
| ram_size_mask | input | RAM_AW | RAM size minus one |
| rom_rd_en | output | 1 | ROM read strobe |
| rom_rd_addr | output | ROM_AW | ROM offset |
| rom_rd_data | input | DATA_W | ROM read byte |
| rom_rd_valid | input | 1 | ROM read byte valid |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM offset for read or write |
| ram_wr_data | output | DATA_W | RAM write byte |
| ram_rd_data | input | DATA_W | RAM read byte |
| ram_rd_valid | input | 1 | RAM read byte valid |

## Verification
The bench builds the block with its defaults: ROM_AW and RAM_AW of 21, an 8-bit data path and a POLL_CYCLES of 6. With 21-bit offsets, every bank of both ROM windows and the whole RAM window can be reached. Smaller masks driven at run time then exercise truncation after folding. A six-cycle interval is short enough to place grant edges exactly one cycle before and one cycle after a sample, and to cover two whole stalled intervals in a single access. The bench memory model has a settable return latency, which separates the ready timing from the strobe timing.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;

  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_ROM  = 2'd1,
    TGT_RAM  = 2'd2
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_HOLD  = 3'd2,
    ST_ISSUE = 3'd3,
    ST_WAIT  = 3'd4,
    ST_RESP  = 3'd5
  } seq_e;

endpackage

// File: rtl/cpbus_rst_sync.sv
module cpbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cpbus_addr_map.sv
module cpbus_addr_map
  import cpbus_pkg::*;
#(
  parameter int ROM_AW = 21,
  parameter int RAM_AW = 21,
  parameter int OFF_W  = 21
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  input  logic [ROM_AW-1:0] rom_mask,
  input  logic [RAM_AW-1:0] ram_mask,
  output tgt_e              tgt,
  output logic [OFF_W-1:0]  off
);
  // lower ROM window packs the upper half of each 64 KB bank
  logic [ADDR_W-1:0] folded;
  logic              win_rom_lo, win_rom_hi, win_ram;
  logic [ROM_AW-1:0] rom_off_lo, rom_off_hi;
  logic [RAM_AW-1:0] ram_off;

  assign folded     = {3'b000, addr[21:16], addr[14:0]};
  assign win_rom_lo = (addr[23:22] == 2'b00);
  assign win_rom_hi = (addr[23:21] == 3'b010);
  assign win_ram    = (addr[23:21] == 3'b011);

  assign rom_off_lo = folded[ROM_AW-1:0] & rom_mask;
  assign rom_off_hi = addr[ROM_AW-1:0] & rom_mask;
  assign ram_off    = addr[RAM_AW-1:0] & ram_mask;

  always_comb begin
    tgt = TGT_NONE;
    off = '0;
    if (win_ram) begin
      tgt = TGT_RAM;
      off[RAM_AW-1:0] = ram_off;
    end else if (!is_write && win_rom_lo) begin
      tgt = TGT_ROM;
      off[ROM_AW-1:0] = rom_off_lo;
    end else if (!is_write && win_rom_hi) begin
      tgt = TGT_ROM;
      off[ROM_AW-1:0] = rom_off_hi;
    end
  end
endmodule

// File: rtl/cpbus_poll_timer.sv
module cpbus_poll_timer #(
  parameter int POLL_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (POLL_CYCLES > 2) ? $clog2(POLL_CYCLES) : 1;
  // sample cycle counts as one cycle of the interval
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(POLL_CYCLES - 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_V;
    end else if (run && cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cpbus_ctrl.sv
module cpbus_ctrl
  import cpbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  tgt_e              tgt_in,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              owned,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic              poll_expired,
  output logic              poll_load,
  output logic              poll_run,
  output logic              issue,
  output tgt_e              tgt_q,
  output logic              write_q,
  output logic [OFF_W-1:0]  off_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              ready,
  output logic [DATA_W-1:0] rdata_q
);
  seq_e              st_q, st_d;
  logic              cap_en, rdata_en;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    st_d      = st_q;
    cap_en    = 1'b0;
    rdata_en  = 1'b0;
    rdata_d   = '0;
    poll_load = 1'b0;
    poll_run  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en   = 1'b1;
          rdata_en = 1'b1;
          st_d     = (tgt_in == TGT_NONE) ? ST_RESP : ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (owned) st_d = ST_ISSUE;
        else begin
          poll_load = 1'b1;
          st_d      = ST_HOLD;
        end
      end
      ST_HOLD: begin
        poll_run = 1'b1;
        if (poll_expired) st_d = ST_CHECK;
      end
      ST_ISSUE: st_d = write_q ? ST_RESP : ST_WAIT;
      ST_WAIT: begin
        if (data_valid) begin
          rdata_en = 1'b1;
          rdata_d  = data_in;
          st_d     = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= TGT_NONE;
      write_q <= 1'b0;
      off_q   <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      tgt_q   <= tgt_in;
      write_q <= req_write;
      off_q   <= off_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign issue = (st_q == ST_ISSUE);
  assign ready = (st_q == ST_RESP);
endmodule

// File: rtl/cpbus_decoder.sv
module cpbus_decoder
  import cpbus_pkg::*;
#(
  parameter int ROM_AW      = 21,
  parameter int RAM_AW      = 21,
  parameter int DATA_W      = 8,
  parameter int POLL_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [23:0]       req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              rom_owned,
  input  logic              ram_owned,
  input  logic [ROM_AW-1:0] rom_size_mask,
  input  logic [RAM_AW-1:0] ram_size_mask,
  output logic              rom_rd_en,
  output logic [ROM_AW-1:0] rom_rd_addr,
  input  logic [DATA_W-1:0] rom_rd_data,
  input  logic              rom_rd_valid,
  output logic              ram_rd_en,
  output logic              ram_wr_en,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wr_data,
  input  logic [DATA_W-1:0] ram_rd_data,
  input  logic              ram_rd_valid
);
  localparam int OFF_W = (ROM_AW > RAM_AW) ? ROM_AW : RAM_AW;

  logic              rst_sync_n;
  tgt_e              map_tgt, tgt_q;
  logic [OFF_W-1:0]  map_off, off_q;
  logic              owned_sel, valid_sel;
  logic [DATA_W-1:0] data_sel;
  logic              poll_load, poll_run, poll_expired;
  logic              issue, write_q;

  cpbus_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cpbus_addr_map #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .OFF_W(OFF_W)) u_map (
    .addr     (req_addr),
    .is_write (req_write),
    .rom_mask (rom_size_mask),
    .ram_mask (ram_size_mask),
    .tgt      (map_tgt),
    .off      (map_off)
  );

  assign owned_sel = (tgt_q == TGT_ROM) ? rom_owned    : ram_owned;
  assign valid_sel = (tgt_q == TGT_ROM) ? rom_rd_valid : ram_rd_valid;
  assign data_sel  = (tgt_q == TGT_ROM) ? rom_rd_data  : ram_rd_data;

  cpbus_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (poll_load),
    .run     (poll_run),
    .expired (poll_expired)
  );

  cpbus_ctrl #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .tgt_in       (map_tgt),
    .off_in       (map_off),
    .wdata_in     (req_wdata),
    .owned        (owned_sel),
    .data_valid   (valid_sel),
    .data_in      (data_sel),
    .poll_expired (poll_expired),
    .poll_load    (poll_load),
    .poll_run     (poll_run),
    .issue        (issue),
    .tgt_q        (tgt_q),
    .write_q      (write_q),
    .off_q        (off_q),
    .wdata_q      (ram_wr_data),
    .ready        (req_ready),
    .rdata_q      (rsp_rdata)
  );

  assign rom_rd_en   = issue && (tgt_q == TGT_ROM);
  assign ram_rd_en   = issue && (tgt_q == TGT_RAM) && !write_q;
  assign ram_wr_en   = issue && (tgt_q == TGT_RAM) && write_q;
  assign rom_rd_addr = off_q[ROM_AW-1:0];
  assign ram_addr    = off_q[RAM_AW-1:0];
endmodule

// File: rtl/cpbus_decoder_chk.sv
module cpbus_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic rom_owned,
  input logic ram_owned,
  input logic rom_rd_en,
  input logic ram_rd_en,
  input logic ram_wr_en,
  input logic req_ready
);
  logic any_strobe;
  assign any_strobe = rom_rd_en || ram_rd_en || ram_wr_en;

  // R6: ROM strobe only after ownership seen high
  a_r6_rom_owned: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_en |-> $past(rom_owned));

  // R6: RAM strobe only after ownership seen high
  a_r6_ram_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd_en || ram_wr_en) |-> $past(ram_owned));

  // R9: never two strobes together
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_rd_en, ram_rd_en, ram_wr_en}));

  // R9: each strobe lasts one cycle
  a_r9_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> !any_strobe);

  // R8: ready is a single-cycle pulse
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R8: completion never coincides with a strobe
  a_r8_ready_not_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !any_strobe);
endmodule

bind cpbus_decoder cpbus_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rom_owned (rom_owned),
  .ram_owned (ram_owned),
  .rom_rd_en (rom_rd_en),
  .ram_rd_en (ram_rd_en),
  .ram_wr_en (ram_wr_en),
  .req_ready (req_ready)
);

// File: tb/sim_cpbus_decoder.sv
module sim_cpbus_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int ROM_AW = 21;
  localparam int RAM_AW = 21;
  localparam int DATA_W = 8;

  logic              clk, rst_n;
  logic              req_valid, req_write;
  logic [23:0]       req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              req_ready;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rom_owned, ram_owned;
  logic [ROM_AW-1:0] rom_size_mask;
  logic [RAM_AW-1:0] ram_size_mask;
  logic              rom_rd_en, rom_rd_valid;
  logic [ROM_AW-1:0] rom_rd_addr;
  logic [DATA_W-1:0] rom_rd_data;
  logic              ram_rd_en, ram_wr_en, ram_rd_valid;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wr_data, ram_rd_data;

  int checks = 0;
  int fails  = 0;
  int mem_delay = 1;
  int rom_pend = 0;
  int ram_pend = 0;
  logic [23:0] rom_cap = '0;
  logic [23:0] ram_cap = '0;

  cpbus_decoder #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .DATA_W(DATA_W), .POLL_CYCLES(6)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .rom_owned(rom_owned), .ram_owned(ram_owned),
    .rom_size_mask(rom_size_mask), .ram_size_mask(ram_size_mask),
    .rom_rd_en(rom_rd_en), .rom_rd_addr(rom_rd_addr),
    .rom_rd_data(rom_rd_data), .rom_rd_valid(rom_rd_valid),
    .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en), .ram_addr(ram_addr),
    .ram_wr_data(ram_wr_data), .ram_rd_data(ram_rd_data),
    .ram_rd_valid(ram_rd_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] model_byte(input bit is_ram, input logic [23:0] off);
    return off[7:0] ^ off[15:8] ^ {3'b000, off[20:16]} ^ (is_ram ? 8'h5A : 8'hC3);
  endfunction

  // memory model: read byte valid mem_delay cycles after the strobe
  always @(posedge clk) begin
    if (rom_rd_en) begin
      rom_pend <= mem_delay;
      rom_cap  <= {3'b000, rom_rd_addr};
    end else if (rom_pend > 0) rom_pend <= rom_pend - 1;
    if (ram_rd_en) begin
      ram_pend <= mem_delay;
      ram_cap  <= {3'b000, ram_addr};
    end else if (ram_pend > 0) ram_pend <= ram_pend - 1;
  end
  assign rom_rd_valid = (rom_pend == 1);
  assign ram_rd_valid = (ram_pend == 1);
  assign rom_rd_data  = model_byte(1'b0, rom_cap);
  assign ram_rd_data  = model_byte(1'b1, ram_cap);

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 rom read, 2 ram read, 3 ram write
  task automatic xfer(input bit wr, input logic [23:0] a, input logic [7:0] wd,
                      input int rom_raise, input int ram_raise,
                      output int n_ready, output int n_strobe, output int strobes,
                      output int kind, output logic [23:0] saddr,
                      output logic [7:0] sdata, output logic [7:0] rd);
    int n;
    n = 0; n_ready = -1; n_strobe = -1; strobes = 0; kind = 0;
    saddr = '0; sdata = '0; rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (1) begin
      @(negedge clk);
      n++;
      if (rom_rd_en) begin strobes++; kind = 1; n_strobe = n; saddr = {3'b000, rom_rd_addr}; end
      if (ram_rd_en) begin strobes++; kind = 2; n_strobe = n; saddr = {3'b000, ram_addr}; end
      if (ram_wr_en) begin strobes++; kind = 3; n_strobe = n; saddr = {3'b000, ram_addr}; sdata = ram_wr_data; end
      if (n == rom_raise) rom_owned = 1'b1;
      if (n == ram_raise) ram_owned = 1'b1;
      if (req_ready) begin
        rd = rsp_rdata; n_ready = n; break;
      end
      if (n > 300) begin
        chk("R9", "transaction never completed", n, 0);
        break;
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R8", "ready pulse width", req_ready, 0);
  endtask

  int nr, ns, st, kd;
  logic [23:0] sa;
  logic [7:0]  sd, rd;

  task automatic t_reset();
    chk("R9", "reset ready", req_ready, 0);
    chk("R9", "reset strobes", {rom_rd_en, ram_rd_en, ram_wr_en}, 0);
    chk("R4", "reset rdata", rsp_rdata, 0);
  endtask

  task automatic t_rom_low();
    xfer(0, 24'h129ABC, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R1", "lo rom kind", kd, 1);
    chk("R1", "lo rom offset", sa, 24'h091ABC);
    chk("R1", "lo rom data", rd, model_byte(0, 24'h091ABC));
    chk("R8", "read ready cycle", nr, 4);
    chk("R9", "one strobe", st, 1);
    xfer(0, 24'h121ABC, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R1", "bit15 ignored", sa, 24'h091ABC);
    xfer(0, 24'h3FFFFF, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R1", "top of lo window", sa, 24'h1FFFFF);
  endtask

  task automatic t_rom_high();
    xfer(0, 24'h456789, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R2", "hi rom kind", kd, 1);
    chk("R2", "hi rom offset", sa, 24'h056789);
    rom_size_mask = 21'h07FFFF;
    xfer(0, 24'h5F1234, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R2", "hi rom masked", sa, 24'h071234);
    chk("R2", "hi rom data", rd, model_byte(0, 24'h071234));
    rom_size_mask = 21'h1FFFFF;
  endtask

  task automatic t_fold_mask();
    rom_size_mask = 21'h0FFFFF;
    xfer(0, 24'h3A8123, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R10", "folded then masked", sa, 24'h0D0123);
    rom_size_mask = 21'h1FFFFF;
  endtask

  task automatic t_ram();
    xfer(0, 24'h704321, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R3", "ram read kind", kd, 2);
    chk("R3", "ram read offset", sa, 24'h004321);
    chk("R3", "ram read data", rd, model_byte(1, 24'h004321));
    xfer(1, 24'h610042, 8'hA5, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R3", "ram write kind", kd, 3);
    chk("R3", "ram write offset", sa, 24'h010042);
    chk("R3", "ram write data", sd, 8'hA5);
    chk("R8", "write ready cycle", nr, 3);
  endtask

  task automatic t_unmapped();
    xfer(0, 24'h801234, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R4", "unmapped strobes", st, 0);
    chk("R4", "unmapped data", rd, 0);
    chk("R4", "unmapped ready cycle", nr, 1);
    xfer(0, 24'hC00000, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R4", "unmapped high data", rd, 0);
  endtask

  task automatic t_write_drop();
    xfer(1, 24'h123456, 8'h3C, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R5", "rom write strobes", st, 0);
    chk("R5", "rom write ready cycle", nr, 1);
    xfer(1, 24'h9F0000, 8'h3C, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R5", "unmapped write strobes", st, 0);
  endtask

  task automatic t_stall();
    rom_owned = 1'b0;
    xfer(0, 24'h400010, 0, 3, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R6", "rom stall strobe count", st, 1);
    chk("R7", "rom strobe after one interval", ns, 8);
    rom_owned = 1'b0;
    xfer(0, 24'h400011, 0, 7, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R7", "grant just before sample", ns, 8);
    rom_owned = 1'b0;
    xfer(0, 24'h400012, 0, 8, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R7", "grant just after sample", ns, 14);
    ram_owned = 1'b0;
    xfer(0, 24'h600020, 0, 0, 9, nr, ns, st, kd, sa, sd, rd);
    chk("R6", "ram stall kind", kd, 2);
    chk("R7", "ram strobe after two intervals", ns, 14);
    chk("R8", "ram stalled ready", nr, 16);
    ram_owned = 1'b0;
    xfer(1, 24'h600021, 8'h11, 0, 3, nr, ns, st, kd, sa, sd, rd);
    chk("R6", "stalled write strobe", ns, 8);
  endtask

  task automatic t_latency();
    mem_delay = 3;
    xfer(0, 24'h450000, 0, 0, 0, nr, ns, st, kd, sa, sd, rd);
    chk("R8", "slow memory ready cycle", nr, 6);
    chk("R8", "slow memory data", rd, model_byte(0, 24'h050000));
    mem_delay = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL R9 watchdog expired: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rom_owned = 1'b1; ram_owned = 1'b1;
    rom_size_mask = 21'h1FFFFF; ram_size_mask = 21'h01FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rom_low();
    t_rom_high();
    t_fold_mask();
    t_ram();
    t_unmapped();
    t_write_drop();
    t_stall();
    t_latency();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule